// File: doc/BRIEF.md
# Condition Code Flag Update Unit

This block computes the next value of an 8-bit processor condition-code register after an ALU step. It is purely combinational. The ALU presents an operation class, an operand width (8 or 16 bits), the two operands, the result it produced, the carry-out of a shift, and the present condition-code value. The unit returns the updated condition-code byte in the same evaluation. The ALU itself lies outside the block.

Carry and overflow for addition and subtraction are not taken from a wide adder. They come from bitwise majority-style expressions over the operands and the result, sampled at the sign bit of the selected width. For 8-bit addition, the same carry expression is sampled at bit 3 to give the half-carry. A separate class lets software-visible logic set or clear any flag by bit mask without an arithmetic operand.

Condition-code layout, bit 7 down to bit 0: S, X, H, I, N, Z, V, C.

Top module: `ccr_flag_unit`

## Requirements
- R1: `opClass` selects the rule. 0 is add, 1 is subtract, 2 is shift, 3 is test/load, 4 is single-flag write. For codes 5, 6 and 7, `ccrOut` equals `ccrIn`.
- R2: For classes 0 to 3, N (bit 3) equals the result sign bit and Z (bit 2) is 1 exactly when the result is zero. The sign bit is `result[7]` when `wideOp`=0 and `result[15]` when `wideOp`=1. With `wideOp`=0, only `result[7:0]` counts toward Z.
- R3: For add, C (bit 0) is the sign-position bit of (a&b)|(b&~r)|(a&~r), and V (bit 1) is the sign-position bit of (a&b&~r)|(~a&~b&r). For a true sum, these are the unsigned carry-out and the signed overflow.
- R4: For subtract, C is the sign-position bit of (~a&b)|(b&r)|(~a&r), and V is the sign-position bit of (a&~b&~r)|(~a&b&r). For a true difference, these are the unsigned borrow and the signed overflow.
- R5: For shift, C equals `shiftCarry`, and V equals the new N XOR `shiftCarry`.
- R6: For test/load, V is cleared and C keeps its value from `ccrIn`.
- R7: For 8-bit add, H (bit 5) is bit 3 of (a&b)|(b&~r)|(a&~r), which is the carry out of the low nibble. For every other case in classes 0 to 3, H keeps its value.
- R8: S (bit 7), X (bit 6) and I (bit 4) are never changed by classes 0 to 3.
- R9: In the single-flag write, bits outside `flagMask` keep their `ccrIn` values. Masked bits become 1 when `flagVal` is nonzero and 0 when it is zero. The operand, result and `shiftCarry` inputs have no effect in this class.
- R10: With `wideOp`=0, bits 15:8 of `opA`, `opB` and `result` have no effect on `ccrOut`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opClass | input | 3 | Operation class code (see R1) |
| wideOp | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| opA | input | 16 | First ALU operand |
| opB | input | 16 | Second ALU operand |
| result | input | 16 | ALU result |
| shiftCarry | input | 1 | Carry bit delivered by the shifter |
| ccrIn | input | 8 | Present condition-code byte |
| flagMask | input | 8 | Bit mask for the single-flag write |
| flagVal | input | 8 | Value for the single-flag write; nonzero sets the masked bits |
| ccrOut | output | 8 | Updated condition-code byte |

## Verification
Every result of this block is due zero clock cycles after its stimulus, because no register lies between the inputs and `ccrOut`. The bench changes the inputs on a falling clock edge and samples `ccrOut` two nanoseconds later, well before the next rising edge. No check therefore depends on process ordering at an edge. The expected bytes come from ordinary integer arithmetic: wide sums, unsigned compares and sign comparisons. The bench never evaluates the majority expressions, so carry, overflow and half-carry are checked against an independent definition.

// File: rtl/ccr_flag_pkg.sv
package ccr_flag_pkg;

  // Condition-code bit positions
  localparam int CC_S = 7;
  localparam int CC_X = 6;
  localparam int CC_H = 5;
  localparam int CC_I = 4;
  localparam int CC_N = 3;
  localparam int CC_Z = 2;
  localparam int CC_V = 1;
  localparam int CC_C = 0;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_SHIFT = 3'd2,
    OP_TEST  = 3'd3,
    OP_FLAG  = 3'd4
  } opClass_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic doAdd;
    logic doSub;
    logic doShift;
    logic doTest;
    logic doFlag;
    logic wide;
    logic halfEn;
  } flagStrobe_t;

endpackage

// File: rtl/ccr_flag_ctrl.sv
module ccr_flag_ctrl
  import ccr_flag_pkg::*;
(
  input  logic [2:0]  opClass,
  input  logic        wideOp,
  output flagStrobe_t strb
);

  always_comb begin
    strb = '0;
    strb.wide = wideOp;
    case (opClass)
      OP_ADD: begin
        strb.doAdd  = 1'b1;
        strb.halfEn = ~wideOp;
      end
      OP_SUB:   strb.doSub   = 1'b1;
      OP_SHIFT: strb.doShift = 1'b1;
      OP_TEST:  strb.doTest  = 1'b1;
      OP_FLAG:  strb.doFlag  = 1'b1;
      default:  strb = '0;
    endcase
  end

endmodule

// File: rtl/ccr_flag_dp.sv
module ccr_flag_dp
  import ccr_flag_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int CCR_W    = 8
) (
  input  flagStrobe_t       strb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] result,
  input  logic              shiftCarry,
  input  logic [CCR_W-1:0]  ccrIn,
  input  logic [CCR_W-1:0]  flagMask,
  input  logic [CCR_W-1:0]  flagVal,
  output logic [CCR_W-1:0]  ccrOut
);

  localparam int WIDE_MSB   = DATA_W - 1;
  localparam int NARROW_MSB = NARROW_W - 1;
  localparam int HALF_BIT   = NARROW_W / 2 - 1;

  logic [DATA_W-1:0] addCarryVec;
  logic [DATA_W-1:0] addOvfVec;
  logic [DATA_W-1:0] subCarryVec;
  logic [DATA_W-1:0] subOvfVec;

  // Per-bit vote terms; only the sign position (and bit 3 for H) is consumed
  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_vote
      assign addCarryVec[gi] = (opA[gi] & opB[gi]) | (opB[gi] & ~result[gi])
                             | (opA[gi] & ~result[gi]);
      assign addOvfVec[gi]   = (opA[gi] & opB[gi] & ~result[gi])
                             | (~opA[gi] & ~opB[gi] & result[gi]);
      assign subCarryVec[gi] = (~opA[gi] & opB[gi]) | (opB[gi] & result[gi])
                             | (~opA[gi] & result[gi]);
      assign subOvfVec[gi]   = (opA[gi] & ~opB[gi] & ~result[gi])
                             | (~opA[gi] & opB[gi] & result[gi]);
    end
  endgenerate

  logic signBit, zeroRes;
  logic addC, addV, subC, subV;

  always_comb begin
    if (strb.wide) begin
      signBit = result[WIDE_MSB];
      zeroRes = ~|result;
      addC    = addCarryVec[WIDE_MSB];
      addV    = addOvfVec[WIDE_MSB];
      subC    = subCarryVec[WIDE_MSB];
      subV    = subOvfVec[WIDE_MSB];
    end else begin
      signBit = result[NARROW_MSB];
      zeroRes = ~|result[NARROW_MSB:0];
      addC    = addCarryVec[NARROW_MSB];
      addV    = addOvfVec[NARROW_MSB];
      subC    = subCarryVec[NARROW_MSB];
      subV    = subOvfVec[NARROW_MSB];
    end
  end

  logic arithAny;
  assign arithAny = strb.doAdd | strb.doSub | strb.doShift | strb.doTest;

  always_comb begin
    ccrOut = ccrIn;
    if (strb.doFlag) begin
      ccrOut = (ccrIn & ~flagMask) | ((|flagVal) ? flagMask : '0);
    end else if (arithAny) begin
      ccrOut[CC_N] = signBit;
      ccrOut[CC_Z] = zeroRes;
      if (strb.doAdd) begin
        ccrOut[CC_C] = addC;
        ccrOut[CC_V] = addV;
      end else if (strb.doSub) begin
        ccrOut[CC_C] = subC;
        ccrOut[CC_V] = subV;
      end else if (strb.doShift) begin
        ccrOut[CC_C] = shiftCarry;
        ccrOut[CC_V] = signBit ^ shiftCarry;
      end else begin
        ccrOut[CC_V] = 1'b0;
      end
      if (strb.halfEn) ccrOut[CC_H] = addCarryVec[HALF_BIT];
    end
  end

endmodule

// File: rtl/ccr_flag_unit.sv
module ccr_flag_unit
  import ccr_flag_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int CCR_W    = 8
) (
  input  logic [2:0]        opClass,
  input  logic              wideOp,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] result,
  input  logic              shiftCarry,
  input  logic [CCR_W-1:0]  ccrIn,
  input  logic [CCR_W-1:0]  flagMask,
  input  logic [CCR_W-1:0]  flagVal,
  output logic [CCR_W-1:0]  ccrOut
);

  flagStrobe_t strb;

  ccr_flag_ctrl u_ctrl (
    .opClass (opClass),
    .wideOp  (wideOp),
    .strb    (strb)
  );

  ccr_flag_dp #(
    .DATA_W   (DATA_W),
    .NARROW_W (NARROW_W),
    .CCR_W    (CCR_W)
  ) u_dp (
    .strb       (strb),
    .opA        (opA),
    .opB        (opB),
    .result     (result),
    .shiftCarry (shiftCarry),
    .ccrIn      (ccrIn),
    .flagMask   (flagMask),
    .flagVal    (flagVal),
    .ccrOut     (ccrOut)
  );

endmodule

// File: rtl/ccr_flag_chk.sv
module ccr_flag_chk
  import ccr_flag_pkg::*;
(
  input logic [2:0]  opClass,
  input logic        wideOp,
  input logic [15:0] opA,
  input logic [15:0] opB,
  input logic [15:0] result,
  input logic        shiftCarry,
  input logic [7:0]  ccrIn,
  input logic [7:0]  flagMask,
  input logic [7:0]  flagVal,
  input logic [7:0]  ccrOut
);

  logic [8:0] narrowSum;
  logic       known;

  always_comb begin
    narrowSum = {1'b0, opA[7:0]} + {1'b0, opB[7:0]};
    known = !$isunknown({opClass, wideOp, opA, opB, result, shiftCarry,
                         ccrIn, flagMask, flagVal, ccrOut});
    if (known) begin
      if (opClass > 3'd4)
        AST_RESERVED_PASS: assert (ccrOut == ccrIn); // R1
      if (opClass <= 3'd3)
        AST_SXI_KEPT: assert ({ccrOut[CC_S], ccrOut[CC_X], ccrOut[CC_I]} ==
                              {ccrIn[CC_S], ccrIn[CC_X], ccrIn[CC_I]}); // R8
      if (opClass <= 3'd3)
        AST_SIGN_FLAG: assert (ccrOut[CC_N] == (wideOp ? result[15] : result[7])); // R2
      if (opClass == 3'd0 && !wideOp && result[7:0] == narrowSum[7:0])
        AST_ADD_CARRY: assert (ccrOut[CC_C] == narrowSum[8]); // R3
      if (opClass == 3'd2)
        AST_SHIFT_OVF: assert (ccrOut[CC_V] == (ccrOut[CC_N] ^ shiftCarry)); // R5
      if (opClass == 3'd3)
        AST_TEST_FLAGS: assert (!ccrOut[CC_V] && ccrOut[CC_C] == ccrIn[CC_C]); // R6
      if (opClass == 3'd4)
        AST_FLAG_WRITE: assert (((ccrOut ^ ccrIn) & ~flagMask) == 8'h00 &&
                                (ccrOut & flagMask) == ((flagVal != 8'h00) ? flagMask : 8'h00)); // R9
    end
  end

endmodule

bind ccr_flag_unit ccr_flag_chk u_chk (.*);

// File: tb/ccr_flag_unit_test.sv
`timescale 1ns/1ps
module ccr_flag_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  opClass = 3'd5;
  logic        wideOp = 1'b0;
  logic [15:0] opA = '0, opB = '0, result = '0;
  logic        shiftCarry = 1'b0;
  logic [7:0]  ccrIn = 8'h00, flagMask = 8'h00, flagVal = 8'h00;
  logic [7:0]  ccrOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk; // 125 MHz

  ccr_flag_unit uut (
    .opClass(opClass), .wideOp(wideOp), .opA(opA), .opB(opB),
    .result(result), .shiftCarry(shiftCarry), .ccrIn(ccrIn),
    .flagMask(flagMask), .flagVal(flagVal), .ccrOut(ccrOut)
  );

  // Independent expectation: integer arithmetic on consistent results
  function automatic logic [7:0] expect_ccr(
      input logic [2:0] cls, input logic w, input logic [15:0] a, b, r,
      input logic sc, input logic [7:0] ccr, mask, val);
    logic [7:0] e;
    int ua, ub, lim;
    logic sa, sb, sn, z;
    e   = ccr;
    ua  = w ? int'(a) : int'(a[7:0]);
    ub  = w ? int'(b) : int'(b[7:0]);
    lim = w ? 65535 : 255;
    sa  = w ? a[15] : a[7];
    sb  = w ? b[15] : b[7];
    sn  = w ? r[15] : r[7];
    z   = w ? (r == 16'h0) : (r[7:0] == 8'h0);
    if (cls <= 3'd3) begin
      e[3] = sn;
      e[2] = z;
    end
    case (cls)
      3'd0: begin
        e[0] = (ua + ub) > lim;
        e[1] = (sa == sb) && (sn != sa);
        if (!w) e[5] = (int'(a[3:0]) + int'(b[3:0])) > 15;
      end
      3'd1: begin
        e[0] = ua < ub;
        e[1] = (sa != sb) && (sn != sa);
      end
      3'd2: begin
        e[0] = sc;
        e[1] = sn ^ sc;
      end
      3'd3: e[1] = 1'b0;
      3'd4: e = (ccr & ~mask) | ((val != 0) ? mask : 8'h00);
      default: e = ccr;
    endcase
    return e;
  endfunction

  task automatic apply_and_check(input string req, input logic [2:0] cls,
      input logic w, input logic [15:0] a, b, r, input logic sc,
      input logic [7:0] ccr, mask, val);
    logic [7:0] exp;
    @(negedge clk);
    opClass = cls; wideOp = w; opA = a; opB = b; result = r;
    shiftCarry = sc; ccrIn = ccr; flagMask = mask; flagVal = val;
    #2;
    exp = expect_ccr(cls, w, a, b, r, sc, ccr, mask, val);
    total++;
    if (ccrOut !== exp) begin
      bad++;
      $display("FAIL %s: class=%0d wide=%0b a=%h b=%h r=%h ccrOut=%h expected=%h",
               req, cls, w, a, b, r, ccrOut, exp);
    end
  endtask

  task automatic test_idle_classes();
    // R1: reserved codes pass ccrIn through, even with busy operands
    apply_and_check("R1", 3'd5, 1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b0, 8'h00, 8'h00, 8'h00);
    apply_and_check("R1", 3'd6, 1'b1, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 8'hA5, 8'hFF, 8'h01);
    apply_and_check("R1", 3'd7, 1'b0, 16'h8080, 16'h7F7F, 16'h0000, 1'b1, 8'h5A, 8'h0F, 8'h00);
  endtask

  task automatic test_add();
    // R3 R7 R2: narrow add overflow with half carry
    apply_and_check("R3", 3'd0, 1'b0, 16'h007F, 16'h0001, 16'h0080, 1'b0, 8'h00, 8'h00, 8'h00);
    // R3 R2 R7: narrow wrap to zero with carry
    apply_and_check("R3", 3'd0, 1'b0, 16'h00FF, 16'h0001, 16'h0000, 1'b0, 8'hD0, 8'h00, 8'h00);
    // R7: no half carry, H previously set must clear
    apply_and_check("R7", 3'd0, 1'b0, 16'h0012, 16'h0021, 16'h0033, 1'b0, 8'h20, 8'h00, 8'h00);
    // R10: junk upper bytes in narrow mode
    apply_and_check("R10", 3'd0, 1'b0, 16'hA57F, 16'h3C01, 16'h9980, 1'b1, 8'h00, 8'h00, 8'h00);
    // R3 wide: signed overflow, H unchanged (R7)
    apply_and_check("R3", 3'd0, 1'b1, 16'h7FFF, 16'h0001, 16'h8000, 1'b0, 8'h20, 8'h00, 8'h00);
    apply_and_check("R3", 3'd0, 1'b1, 16'hFFFF, 16'h0001, 16'h0000, 1'b0, 8'h00, 8'h00, 8'h00);
    apply_and_check("R7", 3'd0, 1'b1, 16'h1238, 16'h0F08, 16'h2140, 1'b0, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic test_sub();
    apply_and_check("R4", 3'd1, 1'b0, 16'h0000, 16'h0001, 16'h00FF, 1'b0, 8'h00, 8'h00, 8'h00);
    apply_and_check("R4", 3'd1, 1'b0, 16'h0080, 16'h0001, 16'h007F, 1'b0, 8'h00, 8'h00, 8'h00);
    apply_and_check("R4", 3'd1, 1'b0, 16'h0005, 16'h0005, 16'h0000, 1'b0, 8'h2F, 8'h00, 8'h00);
    apply_and_check("R4", 3'd1, 1'b1, 16'h8000, 16'h0001, 16'h7FFF, 1'b0, 8'h00, 8'h00, 8'h00);
    apply_and_check("R4", 3'd1, 1'b1, 16'h0000, 16'h0001, 16'hFFFF, 1'b0, 8'hD0, 8'h00, 8'h00);
    // R10: upper bytes differ but narrow difference is zero
    apply_and_check("R10", 3'd1, 1'b0, 16'h1242, 16'h9942, 16'h7700, 1'b0, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic test_shift();
    apply_and_check("R5", 3'd2, 1'b0, 16'h0000, 16'h0000, 16'h0080, 1'b0, 8'h00, 8'h00, 8'h00);
    apply_and_check("R5", 3'd2, 1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b1, 8'h00, 8'h00, 8'h00);
    apply_and_check("R5", 3'd2, 1'b1, 16'h0000, 16'h0000, 16'h4000, 1'b1, 8'h00, 8'h00, 8'h00);
    apply_and_check("R5", 3'd2, 1'b1, 16'h0000, 16'h0000, 16'h8001, 1'b1, 8'hF3, 8'h00, 8'h00);
  endtask

  task automatic test_tst();
    apply_and_check("R6", 3'd3, 1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b0, 8'h03, 8'h00, 8'h00);
    apply_and_check("R6", 3'd3, 1'b1, 16'h0000, 16'h0000, 16'h9000, 1'b0, 8'h06, 8'h00, 8'h00);
    // R2: narrow zero although upper byte nonzero
    apply_and_check("R2", 3'd3, 1'b0, 16'h0000, 16'h0000, 16'hFF00, 1'b0, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic test_flag_write();
    apply_and_check("R9", 3'd4, 1'b0, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b1, 8'h00, 8'h01, 8'h05);
    apply_and_check("R9", 3'd4, 1'b1, 16'h0000, 16'h0001, 16'h8000, 1'b1, 8'hFF, 8'h04, 8'h00);
    apply_and_check("R9", 3'd4, 1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b0, 8'h0F, 8'h80, 8'h80);
    apply_and_check("R9", 3'd4, 1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b0, 8'hFF, 8'h20, 8'h00);
  endtask

  task automatic test_sxi_hold();
    // R8: S, X, I all set; arithmetic classes must keep them
    apply_and_check("R8", 3'd0, 1'b0, 16'h0040, 16'h0040, 16'h0080, 1'b0, 8'hD0, 8'h00, 8'h00);
    apply_and_check("R8", 3'd2, 1'b1, 16'h0000, 16'h0000, 16'h0001, 1'b0, 8'hD0, 8'h00, 8'h00);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    test_idle_classes();
    test_add();
    test_sub();
    test_shift();
    test_tst();
    test_flag_write();
    test_sxi_hold();
    repeat (2) @(posedge clk);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    finish_run();
  end

endmodule